// File: doc/BRIEF.md
# Return Selector Privilege Validator

This block decides whether a far interrupt return, or a return to a nested task through the task back-link, may go ahead. It receives the selectors and the attribute fields of their descriptors after the descriptor tables have been read. It does not read memory. Each descriptor comes with a flag that says its index lay beyond the table limit. The block reports either a pass, or the single highest-priority fault together with the error code that the fault handler should receive.

A one-cycle start strobe captures every input. The code-side checks, or the back-link checks, run in the next cycle. When the return changes to an outer privilege level, or when the wide-pop mode forces the stack selector to be popped, the stack-side checks run one cycle after that. The result is flagged with a one-cycle done pulse. The fault outputs then hold their value until the next done pulse.

Top module: `ret_sel_validator`

## Requirements
- R1: In interrupt-return mode (task_mode=0), a code selector whose bits [15:2] are all zero gives a general-protection fault (fault_kind=1) with error code 0. This check takes priority over every other check.
- R2: After R1, if rc_lim_err is set, the result is a general-protection fault. The error code is the code selector with bits [1:0] cleared.
- R3: After R2, if the code selector RPL (bits [1:0]) is numerically below cpl, the result is a general-protection fault. The error code is the code selector with bits [1:0] cleared. An RPL equal to or above cpl does not fault.
- R4: When RPL equals cpl and wide_pop is 0, the return passes (fault_kind=0, fault_code=0) with done high 2 clock edges after the start edge. No stack input is examined. When RPL is above cpl, or when wide_pop is 1, the stack checks run and done comes 3 edges after the start edge. A pass always carries fault_code 0.
- R5: A stack selector with bits [15:2] all zero passes, and skips R6 to R8, only if rc_long is 1 and the code RPL is not 3. Otherwise it is a general-protection fault with error code 0.
- R6: If the stack selector RPL differs from the code RPL, the result is a general-protection fault. After that check, rs_lim_err gives a general-protection fault. Both faults carry the stack selector with bits [1:0] cleared.
- R7: Next, the stack descriptor must have rs_valid=1, rs_seg=1, rs_exec=0 and rs_write=1. Its rs_dpl must then equal the code RPL. Either violation is a general-protection fault on the cleared stack selector.
- R8: Last, rs_present=0 gives a segment-not-present fault (fault_kind=2) on the cleared stack selector. A type or DPL violation on the same selector is reported instead of this fault.
- R9: In task mode (task_mode=1), the back-link selector is taken on rc_sel. The checks run in this order: table bit [2] set, then rc_lim_err, then a descriptor that is not (rc_valid=1, rc_seg=0, rc_type 4'h3 or 4'hB). Each of these gives an invalid-task-segment fault (fault_kind=3). Then rc_present=0 gives a not-present fault. The error code is rc_sel with bits [1:0] cleared. Done comes 2 edges after start, and the stack inputs are ignored.
- R10: After reset, busy, done, fault_kind and fault_code are all 0. done is a one-cycle pulse with busy low. The fault outputs change only with done. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture inputs and begin a check |
| task_mode | input | 1 | 1: nested-task back-link check; 0: interrupt return |
| wide_pop | input | 1 | Force stack checks even at the same privilege level |
| cpl | input | 2 | Current privilege level |
| rc_sel | input | 16 | Return code selector, or back-link selector |
| rc_lim_err | input | 1 | Code/link index beyond table limit |
| rc_valid | input | 1 | Code/link descriptor valid |
| rc_seg | input | 1 | Code/link descriptor is a code/data segment (not system) |
| rc_type | input | 4 | Code/link descriptor type |
| rc_present | input | 1 | Code/link descriptor present |
| rc_long | input | 1 | Return code segment is a 64-bit segment |
| rs_sel | input | 16 | Return stack selector |
| rs_lim_err | input | 1 | Stack index beyond table limit |
| rs_valid | input | 1 | Stack descriptor valid |
| rs_seg | input | 1 | Stack descriptor is a code/data segment |
| rs_exec | input | 1 | Stack descriptor is executable |
| rs_write | input | 1 | Stack descriptor is writable |
| rs_dpl | input | 2 | Stack descriptor privilege level |
| rs_present | input | 1 | Stack descriptor present |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle result pulse |
| fault_kind | output | 2 | 0 none, 1 general-protection, 2 not-present, 3 invalid task segment |
| fault_code | output | 16 | Error code of the reported fault |

## Verification
The properties assume that a start strobe counts only while busy is low. They also assume that every selector and descriptor field is valid in the start cycle alone, since the block captures them at that edge and never looks at the ports again. The stimulus raises start for exactly one cycle while the block is idle, with all fields set up at the same falling edge. One scenario deliberately pulses start while busy and checks that only one result appears. The cases step through each rung of the priority ladder, setting a higher and a lower violation together wherever the order matters.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_GP   = 2'd1,
        FK_NP   = 2'd2,
        FK_TS   = 2'd3
    } fault_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CODE  = 2'd1,
        ST_STACK = 2'd2
    } stage_e;

    // busy task-segment descriptor types accepted on a back-link
    localparam logic [3:0] TSS16_BUSY = 4'h3;
    localparam logic [3:0] TSS32_BUSY = 4'hB;

    localparam int RPL_W = 2;

endpackage

// File: rtl/rsv_code_stage.sv
module rsv_code_stage
    import rsv_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic                task_mode,
    input  logic                wide_pop,
    input  logic [RPL_W-1:0]    cpl,
    input  logic [SEL_W-1:0]    sel,
    input  logic                lim_err,
    input  logic                dvalid,
    input  logic                dseg,
    input  logic [3:0]          dtype,
    input  logic                dpresent,
    output logic                fail,
    output fault_kind_e         kind,
    output logic [SEL_W-1:0]    ecode,
    output logic                go_stack
);
    localparam int TI_BIT = RPL_W;

    logic [SEL_W-1:0] sel_clr;
    logic             sel_null;
    logic [RPL_W-1:0] rpl;
    logic             busy_tss;

    assign sel_clr  = {sel[SEL_W-1:RPL_W], {RPL_W{1'b0}}};
    assign sel_null = (sel[SEL_W-1:RPL_W] == '0);
    assign rpl      = sel[RPL_W-1:0];
    assign busy_tss = (dtype == TSS16_BUSY) || (dtype == TSS32_BUSY);

    always_comb begin
        fail     = 1'b0;
        kind     = FK_NONE;
        ecode    = '0;
        go_stack = 1'b0;
        if (task_mode) begin
            if (sel[TI_BIT] || lim_err || !dvalid || dseg || !busy_tss) begin
                fail  = 1'b1;
                kind  = FK_TS;
                ecode = sel_clr;
            end else if (!dpresent) begin
                fail  = 1'b1;
                kind  = FK_NP;
                ecode = sel_clr;
            end
        end else begin
            if (sel_null) begin
                fail = 1'b1;
                kind = FK_GP;
            end else if (lim_err || (rpl < cpl)) begin
                fail  = 1'b1;
                kind  = FK_GP;
                ecode = sel_clr;
            end else begin
                go_stack = (rpl != cpl) || wide_pop;
            end
        end
    end

endmodule

// File: rtl/rsv_stack_stage.sv
module rsv_stack_stage
    import rsv_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic [RPL_W-1:0]    code_rpl,
    input  logic                code_long,
    input  logic [SEL_W-1:0]    sel,
    input  logic                lim_err,
    input  logic                dvalid,
    input  logic                dseg,
    input  logic                dexec,
    input  logic                dwrite,
    input  logic [RPL_W-1:0]    ddpl,
    input  logic                dpresent,
    output fault_kind_e         kind,
    output logic [SEL_W-1:0]    ecode
);
    localparam logic [RPL_W-1:0] OUTER_RING = {RPL_W{1'b1}};

    logic [SEL_W-1:0] sel_clr;
    logic             sel_null;
    logic             bad_type;

    assign sel_clr  = {sel[SEL_W-1:RPL_W], {RPL_W{1'b0}}};
    assign sel_null = (sel[SEL_W-1:RPL_W] == '0);
    assign bad_type = !dvalid || !dseg || dexec || !dwrite;

    always_comb begin
        kind  = FK_NONE;
        ecode = '0;
        if (sel_null) begin
            if (!code_long || (code_rpl == OUTER_RING)) begin
                kind = FK_GP;
            end
        end else if ((sel[RPL_W-1:0] != code_rpl) || lim_err ||
                     bad_type || (ddpl != code_rpl)) begin
            kind  = FK_GP;
            ecode = sel_clr;
        end else if (!dpresent) begin
            kind  = FK_NP;
            ecode = sel_clr;
        end
    end

endmodule

// File: rtl/ret_sel_validator.sv
module ret_sel_validator
    import rsv_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             task_mode,
    input  logic             wide_pop,
    input  logic [1:0]       cpl,
    input  logic [SEL_W-1:0] rc_sel,
    input  logic             rc_lim_err,
    input  logic             rc_valid,
    input  logic             rc_seg,
    input  logic [3:0]       rc_type,
    input  logic             rc_present,
    input  logic             rc_long,
    input  logic [SEL_W-1:0] rs_sel,
    input  logic             rs_lim_err,
    input  logic             rs_valid,
    input  logic             rs_seg,
    input  logic             rs_exec,
    input  logic             rs_write,
    input  logic [1:0]       rs_dpl,
    input  logic             rs_present,
    output logic             busy,
    output logic             done,
    output logic [1:0]       fault_kind,
    output logic [SEL_W-1:0] fault_code
);
    typedef struct packed {
        stage_e           stage;
        logic             task_m;
        logic             wide;
        logic [RPL_W-1:0] cpl;
        logic [SEL_W-1:0] csel;
        logic             c_lim;
        logic             c_valid;
        logic             c_seg;
        logic [3:0]       c_type;
        logic             c_pres;
        logic             c_long;
        logic [SEL_W-1:0] ssel;
        logic             s_lim;
        logic             s_valid;
        logic             s_seg;
        logic             s_exec;
        logic             s_write;
        logic [RPL_W-1:0] s_dpl;
        logic             s_pres;
        logic             done;
        fault_kind_e      kind;
        logic [SEL_W-1:0] code;
    } regs_t;

    localparam regs_t REGS_RST = '0;

    regs_t st_d, st_q;

    logic             cs_fail;
    fault_kind_e      cs_kind;
    logic [SEL_W-1:0] cs_code;
    logic             cs_go_stack;
    fault_kind_e      ss_kind;
    logic [SEL_W-1:0] ss_code;

    rsv_code_stage #(.SEL_W(SEL_W)) u_code (
        .task_mode (st_q.task_m),
        .wide_pop  (st_q.wide),
        .cpl       (st_q.cpl),
        .sel       (st_q.csel),
        .lim_err   (st_q.c_lim),
        .dvalid    (st_q.c_valid),
        .dseg      (st_q.c_seg),
        .dtype     (st_q.c_type),
        .dpresent  (st_q.c_pres),
        .fail      (cs_fail),
        .kind      (cs_kind),
        .ecode     (cs_code),
        .go_stack  (cs_go_stack)
    );

    rsv_stack_stage #(.SEL_W(SEL_W)) u_stack (
        .code_rpl  (st_q.csel[RPL_W-1:0]),
        .code_long (st_q.c_long),
        .sel       (st_q.ssel),
        .lim_err   (st_q.s_lim),
        .dvalid    (st_q.s_valid),
        .dseg      (st_q.s_seg),
        .dexec     (st_q.s_exec),
        .dwrite    (st_q.s_write),
        .ddpl      (st_q.s_dpl),
        .dpresent  (st_q.s_pres),
        .kind      (ss_kind),
        .ecode     (ss_code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.stage)
            ST_IDLE: begin
                if (start) begin
                    st_d.stage   = ST_CODE;
                    st_d.task_m  = task_mode;
                    st_d.wide    = wide_pop;
                    st_d.cpl     = cpl;
                    st_d.csel    = rc_sel;
                    st_d.c_lim   = rc_lim_err;
                    st_d.c_valid = rc_valid;
                    st_d.c_seg   = rc_seg;
                    st_d.c_type  = rc_type;
                    st_d.c_pres  = rc_present;
                    st_d.c_long  = rc_long;
                    st_d.ssel    = rs_sel;
                    st_d.s_lim   = rs_lim_err;
                    st_d.s_valid = rs_valid;
                    st_d.s_seg   = rs_seg;
                    st_d.s_exec  = rs_exec;
                    st_d.s_write = rs_write;
                    st_d.s_dpl   = rs_dpl;
                    st_d.s_pres  = rs_present;
                end
            end
            ST_CODE: begin
                if (!cs_fail && cs_go_stack) begin
                    st_d.stage = ST_STACK;
                end else begin
                    st_d.stage = ST_IDLE;
                    st_d.done  = 1'b1;
                    st_d.kind  = cs_kind;
                    st_d.code  = cs_code;
                end
            end
            ST_STACK: begin
                st_d.stage = ST_IDLE;
                st_d.done  = 1'b1;
                st_d.kind  = ss_kind;
                st_d.code  = ss_code;
            end
            default: begin
                st_d.stage = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= REGS_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = (st_q.stage != ST_IDLE);
    assign done       = st_q.done;
    assign fault_kind = st_q.kind;
    assign fault_code = st_q.code;

endmodule

// File: rtl/rsv_checker.sv
module rsv_checker
    import rsv_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             task_mode,
    input logic [SEL_W-1:0] rc_sel,
    input logic             busy,
    input logic             done,
    input logic [1:0]       fault_kind,
    input logic [SEL_W-1:0] fault_code
);
    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a result is only presented once the block is idle
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: outputs change only together with done
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(fault_kind) && $stable(fault_code)));

    // R1: null return code selector gives general protection with code 0
    p_null_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !task_mode && (rc_sel[SEL_W-1:2] == '0))
        |=> ##1 (done && (fault_kind == FK_GP) && (fault_code == '0)));

    // R9: a back-link pointing at the local table is an invalid task segment
    p_link_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && task_mode && rc_sel[2])
        |=> ##1 (done && (fault_kind == FK_TS)));

    // R4: a pass carries a zero error code
    p_pass_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (fault_kind == FK_NONE)) |-> (fault_code == '0));

endmodule

bind ret_sel_validator rsv_checker #(.SEL_W(SEL_W)) u_rsv_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .task_mode  (task_mode),
    .rc_sel     (rc_sel),
    .busy       (busy),
    .done       (done),
    .fault_kind (fault_kind),
    .fault_code (fault_code)
);

// File: tb/ret_sel_validator_tb.sv
module ret_sel_validator_tb;

    localparam logic [1:0] K_NONE = 2'd0;
    localparam logic [1:0] K_GP   = 2'd1;
    localparam logic [1:0] K_NP   = 2'd2;
    localparam logic [1:0] K_TS   = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n, start, task_mode, wide_pop;
    logic [1:0]  cpl;
    logic [15:0] rc_sel;
    logic        rc_lim_err, rc_valid, rc_seg, rc_present, rc_long;
    logic [3:0]  rc_type;
    logic [15:0] rs_sel;
    logic        rs_lim_err, rs_valid, rs_seg, rs_exec, rs_write, rs_present;
    logic [1:0]  rs_dpl;
    logic        busy, done;
    logic [1:0]  fault_kind;
    logic [15:0] fault_code;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    typedef struct {
        string       tag;
        logic [1:0]  kind;
        logic [15:0] code;
        int          lat;
        int          t0;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ret_sel_validator u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .task_mode(task_mode),
        .wide_pop(wide_pop), .cpl(cpl), .rc_sel(rc_sel), .rc_lim_err(rc_lim_err),
        .rc_valid(rc_valid), .rc_seg(rc_seg), .rc_type(rc_type),
        .rc_present(rc_present), .rc_long(rc_long), .rs_sel(rs_sel),
        .rs_lim_err(rs_lim_err), .rs_valid(rs_valid), .rs_seg(rs_seg),
        .rs_exec(rs_exec), .rs_write(rs_write), .rs_dpl(rs_dpl),
        .rs_present(rs_present), .busy(busy), .done(done),
        .fault_kind(fault_kind), .fault_code(fault_code)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a result appears
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected done", {30'd0, fault_kind}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check((fault_kind == e.kind) && (fault_code == e.code) &&
                      ((cyc - e.t0) == e.lat), e.tag, "kind/code/latency",
                      {fault_kind, fault_code, 8'd0, 6'(cyc - e.t0)},
                      {e.kind, e.code, 8'd0, 6'(e.lat)});
            end
        end
    end

    // good outer return from ring 0 to ring 3
    task automatic base();
        task_mode  = 1'b0; wide_pop = 1'b0; cpl = 2'd0;
        rc_sel     = 16'h001B; rc_lim_err = 1'b0; rc_valid = 1'b1;
        rc_seg     = 1'b1; rc_type = 4'hA; rc_present = 1'b1; rc_long = 1'b0;
        rs_sel     = 16'h0023; rs_lim_err = 1'b0; rs_valid = 1'b1; rs_seg = 1'b1;
        rs_exec    = 1'b0; rs_write = 1'b1; rs_dpl = 2'd3; rs_present = 1'b1;
    endtask

    task automatic link_base();
        base();
        task_mode = 1'b1; rc_sel = 16'h0028; rc_seg = 1'b0; rc_type = 4'hB;
        rs_sel = 16'h0000; rs_valid = 1'b0;
    endtask

    // driver: starts one check, queues the expected result, waits it out
    task automatic issue(input string tag, input logic [1:0] k,
                         input logic [15:0] c, input int lat);
        exp_t e;
        e.tag = tag; e.kind = k; e.code = c; e.lat = lat; e.t0 = cyc;
        sb.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            check(1'b0, tag, "no done seen", 32'd0, 32'd1);
            sb.delete();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0;
        base();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && fault_kind == K_NONE && fault_code == 16'h0,
              "R10", "reset state", {busy, done, fault_kind, fault_code}, 32'd0);

        // R1: null code selector, also ahead of a limit error
        base(); rc_sel = 16'h0003; rc_lim_err = 1'b1;
        issue("R1", K_GP, 16'h0000, 2);
        // R2: limit error, also ahead of an RPL violation
        base(); rc_lim_err = 1'b1; cpl = 2'd3; rc_sel = 16'h0019;
        issue("R2", K_GP, 16'h0018, 2);
        // R3: RPL below CPL
        base(); cpl = 2'd3; rc_sel = 16'h0019;
        issue("R3", K_GP, 16'h0018, 2);
        // R4: outer pass, three edges
        base();
        issue("R4", K_NONE, 16'h0000, 3);
        // R4: same level ignores a bad stack selector, two edges
        base(); cpl = 2'd3; rs_sel = 16'h0000; rs_present = 1'b0;
        issue("R4", K_NONE, 16'h0000, 2);
        // R4: wide pop forces stack stage at the same level
        base(); cpl = 2'd3; wide_pop = 1'b1;
        issue("R4", K_NONE, 16'h0000, 3);
        // R5: null stack allowed for 64-bit code below ring 3
        base(); rc_sel = 16'h0011; rc_long = 1'b1; rs_sel = 16'h0002; rs_present = 1'b0;
        issue("R5", K_NONE, 16'h0000, 3);
        // R5: null stack not allowed in ring 3 even for 64-bit code
        base(); rc_long = 1'b1; rs_sel = 16'h0003;
        issue("R5", K_GP, 16'h0000, 3);
        // R5: null stack with non-64-bit code
        base(); cpl = 2'd3; wide_pop = 1'b1; rs_sel = 16'h0000;
        issue("R5", K_GP, 16'h0000, 3);
        // R6: stack RPL mismatch, ahead of limit error
        base(); rs_sel = 16'h0022; rs_lim_err = 1'b1;
        issue("R6", K_GP, 16'h0020, 3);
        // R6: stack limit error
        base(); rs_lim_err = 1'b1;
        issue("R6", K_GP, 16'h0020, 3);
        // R7: executable stack
        base(); rs_exec = 1'b1;
        issue("R7", K_GP, 16'h0020, 3);
        // R7: read-only stack
        base(); rs_write = 1'b0;
        issue("R7", K_GP, 16'h0020, 3);
        // R7: system descriptor as stack
        base(); rs_seg = 1'b0;
        issue("R7", K_GP, 16'h0020, 3);
        // R7: DPL mismatch
        base(); rs_dpl = 2'd2;
        issue("R7", K_GP, 16'h0020, 3);
        // R8: not present
        base(); rs_present = 1'b0;
        issue("R8", K_NP, 16'h0020, 3);
        // R8: DPL violation outranks not present
        base(); rs_present = 1'b0; rs_dpl = 2'd1;
        issue("R8", K_GP, 16'h0020, 3);

        // R9: back-link checks, stack inputs left invalid
        link_base();
        issue("R9", K_NONE, 16'h0000, 2);
        link_base(); rc_type = 4'h3;
        issue("R9", K_NONE, 16'h0000, 2);
        link_base(); rc_sel = 16'h002E; rc_present = 1'b0;
        issue("R9", K_TS, 16'h002C, 2);
        link_base(); rc_lim_err = 1'b1;
        issue("R9", K_TS, 16'h0028, 2);
        link_base(); rc_type = 4'h9;
        issue("R9", K_TS, 16'h0028, 2);
        link_base(); rc_seg = 1'b1;
        issue("R9", K_TS, 16'h0028, 2);
        link_base(); rc_present = 1'b0;
        issue("R9", K_NP, 16'h0028, 2);

        // R10: start while busy is ignored
        begin
            exp_t e;
            base();
            e.tag = "R10"; e.kind = K_NONE; e.code = 16'h0; e.lat = 3; e.t0 = cyc;
            sb.push_back(e);
            start = 1'b1;
            @(negedge clk);
            rc_sel = 16'h0000;
            @(negedge clk);
            start = 1'b0;
            repeat (5) @(negedge clk);
            check(sb.size() == 0, "R10", "busy start ignored", sb.size(), 0);
        end

        // R10: outputs hold after done
        base(); rs_present = 1'b0;
        issue("R10", K_NP, 16'h0020, 3);
        repeat (6) @(negedge clk);
        check(fault_kind == K_NP && fault_code == 16'h0020 && !done, "R10",
              "hold", {14'd0, fault_kind, fault_code}, {14'd0, K_NP, 16'h0020});

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule